// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block converts a 32-bit linear address into a physical address by reading a page directory and then a page table from memory. The linear address splits into three fields: the top ten bits select a directory slot, the next ten bits select a table slot, and the low twelve bits are the byte offset inside a 4 KB page. A base register supplies the physical location of the directory. When the directory entry is marked as a large page and large pages are enabled, the walk stops after one level and maps a whole 4 MB region.

Each request also carries the access type (read or write) and the privilege (user or supervisor). The walker checks the present, writable and user bits at every level it visits. A failed check ends the walk with a fault. The fault level is reported, and the linear address that caused it is kept in a fault register until the next fault. When paging is disabled, the walker returns the linear address unchanged and makes no memory read. Memory is reached through a plain synchronous read port whose data returns one cycle after the read strobe.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `done`, `fault`, `fault_lvl`, `busy` and `mem_rd_en` are 0, and `phys_addr` and `fault_lin` are 0.
- R2: A request accepted while `pg_en` is 0 makes no memory read. `done` rises at the accepting clock edge with `fault` 0 and `phys_addr` equal to the linear address.
- R3: A request accepted with `pg_en` 1 drives `mem_rd_en` in the next cycle at byte address {dir_base[31:12], lin[31:22], 2'b00}. The low 12 bits of `dir_base` are ignored. Address 0x01802038 therefore reads directory slot 6, and its table slot is 2 and its offset is 0x38.
- R4: Entry encoding: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 7 page size, bits 31:12 frame base. If the directory entry passes its checks and does not map a large page, the table entry is read two cycles after the directory read, at {pde[31:12], lin[21:12], 2'b00}. A walk with no fault gives {pte[31:12], lin[11:0]}, and `done` rises on the fourth edge after acceptance. The accessed bit does not affect the result.
- R5: A directory entry with present bit 0 ends the walk with `fault`=1 and `fault_lvl`=0 on the second edge after acceptance, and no table read is made.
- R6: A table entry with present bit 0 gives `fault`=1 and `fault_lvl`=1.
- R7: A user request faults if the user bit is 0 in either entry it reaches. A supervisor request ignores the user bit.
- R8: A user write faults if the writable bit is 0 at either level. A supervisor write to a non-writable page faults only when `wp_en` was 1 at acceptance. Reads never fault on the writable bit.
- R9: If `big_en` was 1 at acceptance and the directory entry passes its checks and has bit 7 set, the result is {pde[31:22], lin[21:0]} on the second edge, with no table read. If `big_en` was 0, bit 7 is ignored and a normal two-level walk follows.
- R10: `fault_lin` loads the request's linear address only when a walk ends in a fault. It holds its value through translations that succeed.
- R11: `busy` is 1 from the accepting edge until the edge that raises `done`. A `req_valid` seen while `busy` is 1 is ignored.
- R12: `done` is high for one cycle per request. `phys_addr`, `fault` and `fault_lvl` change only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translate request, accepted when not busy |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| pg_en | input | 1 | Paging enabled |
| wp_en | input | 1 | Supervisor write protection enabled |
| big_en | input | 1 | Large (4 MB) pages enabled |
| dir_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_data | input | 32 | Entry data, valid one cycle after the strobe |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last completed request faulted |
| fault_lvl | output | 1 | Level of the last fault: 0 directory, 1 table |
| phys_addr | output | 32 | Last successful physical address |
| fault_lin | output | 32 | Linear address of the most recent fault |

## Verification
The assertions assume that memory returns entry data exactly one cycle after a read strobe. They also assume that `req_lin`, `dir_base` and the mode bits are valid in the cycle where `req_valid` meets an idle walker, since the checks compare the read address with the values latched at that point. The bench drives a memory model with this one-cycle latency and changes the request fields only at falling edges. It also raises an extra request in the middle of a walk to show that the request is dropped and the latched fields are unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int TBL_W    = 10;
    localparam int DIR_W    = 10;
    localparam int FRAME_W  = VA_W - OFF_W;
    localparam int BIG_OFF  = OFF_W + TBL_W;
    localparam int BIG_FR_W = VA_W - BIG_OFF;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [3:0]         avail;
        logic               big;
        logic               dirty;
        logic               acc;
        logic               nocache;
        logic               wthru;
        logic               usr;
        logic               wr;
        logic               pres;
    } ent_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DIR_RD, ST_DIR_CHK, ST_TBL_RD, ST_TBL_CHK
    } st_t;

    typedef struct packed {
        logic [VA_W-1:0]    lin;
        logic [FRAME_W-1:0] base;
        logic               wr;
        logic               usr;
        logic               wp;
        logic               big;
    } req_t;

    function automatic logic [DIR_W-1:0] dir_idx(input logic [VA_W-1:0] a);
        return a[VA_W-1 -: DIR_W];
    endfunction

    function automatic logic [TBL_W-1:0] tbl_idx(input logic [VA_W-1:0] a);
        return a[OFF_W +: TBL_W];
    endfunction

    function automatic logic access_bad(input ent_t e, input logic wr,
                                        input logic usr, input logic wp);
        logic no_user, no_write;
        no_user  = usr && !e.usr;
        no_write = wr && !e.wr && (usr || wp);
        return !e.pres || no_user || no_write;
    endfunction
endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic pg_en,
    input  logic chk_bad,
    input  logic chk_big,
    output logic accept,
    output logic bypass,
    output logic finish,
    output logic at_table,
    output logic pde_ok,
    output logic rd_en,
    output logic rd_lvl,
    output logic busy
);
    st_t st, st_n;

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE:    if (req_valid && pg_en) st_n = ST_DIR_RD;
            ST_DIR_RD:  st_n = ST_DIR_CHK;
            ST_DIR_CHK: st_n = (chk_bad || chk_big) ? ST_IDLE : ST_TBL_RD;
            ST_TBL_RD:  st_n = ST_TBL_CHK;
            ST_TBL_CHK: st_n = ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    assign accept   = (st == ST_IDLE) && req_valid;
    assign bypass   = accept && !pg_en;
    assign at_table = (st == ST_TBL_CHK);
    assign pde_ok   = (st == ST_DIR_CHK) && !chk_bad;
    assign finish   = ((st == ST_DIR_CHK) && (chk_bad || chk_big)) || at_table;
    assign rd_en    = (st == ST_DIR_RD) || (st == ST_TBL_RD);
    assign rd_lvl   = (st == ST_TBL_RD);
    assign busy     = (st != ST_IDLE);
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
    import ptw_pkg::*;
#(
    parameter bit BIG_PAGES = 1'b1
) (
    input  logic [VA_W-1:0] raw,
    input  req_t            rq,
    input  logic            lvl,
    output logic            bad,
    output logic            big_hit,
    output logic [VA_W-1:0] phys
);
    ent_t e;
    assign e   = ent_t'(raw);
    assign bad = access_bad(e, rq.wr, rq.usr, rq.wp);

    generate
        if (BIG_PAGES) begin : g_big
            assign big_hit = !lvl && rq.big && e.big && !bad;
        end else begin : g_nobig
            assign big_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        if (lvl) phys = {e.frame, rq.lin[OFF_W-1:0]};
        else     phys = {e.frame[FRAME_W-1 -: BIG_FR_W], rq.lin[BIG_OFF-1:0]};
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic               lvl,
    input  req_t               rq,
    input  logic [FRAME_W-1:0] pde_frame,
    output logic [VA_W-1:0]    addr
);
    localparam int PAD = VA_W - FRAME_W - DIR_W;

    always_comb begin
        if (lvl) addr = {pde_frame, tbl_idx(rq.lin), {PAD{1'b0}}};
        else     addr = {rq.base, dir_idx(rq.lin), {PAD{1'b0}}};
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter bit BIG_PAGES = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_lin,
    input  logic        req_write,
    input  logic        req_user,
    input  logic        pg_en,
    input  logic        wp_en,
    input  logic        big_en,
    input  logic [31:0] dir_base,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic [31:0] mem_rd_data,
    output logic        busy,
    output logic        done,
    output logic        fault,
    output logic        fault_lvl,
    output logic [31:0] phys_addr,
    output logic [31:0] fault_lin
);
    req_t               rq;
    logic [FRAME_W-1:0] pde_frame;
    logic               accept, bypass, finish, at_table, pde_ok, rd_lvl;
    logic               chk_bad, chk_big;
    logic [VA_W-1:0]    chk_phys;

    ptw_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .pg_en(pg_en),
        .chk_bad(chk_bad), .chk_big(chk_big), .accept(accept),
        .bypass(bypass), .finish(finish), .at_table(at_table),
        .pde_ok(pde_ok), .rd_en(mem_rd_en), .rd_lvl(rd_lvl), .busy(busy)
    );

    ptw_entry_chk #(.BIG_PAGES(BIG_PAGES)) u_chk_ent (
        .raw(mem_rd_data), .rq(rq), .lvl(at_table),
        .bad(chk_bad), .big_hit(chk_big), .phys(chk_phys)
    );

    ptw_addr_gen u_addr (
        .lvl(rd_lvl), .rq(rq), .pde_frame(pde_frame), .addr(mem_rd_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rq        <= '0;
            pde_frame <= '0;
            done      <= 1'b0;
            fault     <= 1'b0;
            fault_lvl <= 1'b0;
            phys_addr <= '0;
            fault_lin <= '0;
        end else begin
            done <= bypass || finish;
            if (accept) begin
                rq.lin  <= req_lin;
                rq.base <= dir_base[VA_W-1:OFF_W];
                rq.wr   <= req_write;
                rq.usr  <= req_user;
                rq.wp   <= wp_en;
                rq.big  <= big_en;
            end
            if (pde_ok) pde_frame <= mem_rd_data[VA_W-1:OFF_W];
            if (bypass) begin
                phys_addr <= req_lin;
                fault     <= 1'b0;
                fault_lvl <= 1'b0;
            end else if (finish) begin
                fault     <= chk_bad;
                fault_lvl <= at_table;
                if (chk_bad) fault_lin <= rq.lin;
                else         phys_addr <= chk_phys;
            end
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_lin,
    input logic        pg_en,
    input logic [31:0] dir_base,
    input logic        mem_rd_en,
    input logic [31:0] mem_rd_addr,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic [31:0] phys_addr,
    input logic [31:0] fault_lin
);
    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !pg_en) |=> (done && !fault && phys_addr == $past(req_lin)));

    a_r3_dir_address: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && pg_en) |=>
            (mem_rd_en && mem_rd_addr == {$past(dir_base[31:12]), $past(req_lin[31:22]), 2'b00}));

    a_r10_flin_only_on_fault: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_lin) |-> (done && fault));

    a_r11_read_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

    a_r12_result_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(phys_addr) |-> done);
endmodule

bind ptw_walker ptw_walker_chk u_walker_chk (.*);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0, req_user = 1'b0;
    logic        pg_en = 1'b0, wp_en = 1'b0, big_en = 1'b0;
    logic [31:0] dir_base = 32'h0001_0ABC;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        busy, done, fault, fault_lvl;
    logic [31:0] phys_addr, fault_lin;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] mem [int];
    logic [31:0] exp_flin = '0;

    ptw_walker dut (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(int'(a >> 2)) ? mem[int'(a >> 2)] : 32'h0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (mem_rd_en) mem_rd_data <= rd(mem_rd_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic bit lvl_bad(input logic [31:0] e, input bit wr, input bit usr, input bit wp);
        if (e[0] == 1'b0) return 1'b1;
        if (usr && e[2] == 1'b0) return 1'b1;
        if (wr && e[1] == 1'b0 && (usr || wp)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic do_req(input logic [31:0] lin, input bit wr, input bit usr,
                          input bit pg, input bit wp, input bit big,
                          input bit intrude, input string tag);
        int lat; bit ef, el, tbl; logic [31:0] ephys, adir, atbl, pde, pte;
        adir = {dir_base[31:12], 12'h0} + (lin >> 22) * 4;
        pde  = rd(adir);
        atbl = {pde[31:12], 12'h0} + ((lin >> 12) & 32'h3FF) * 4;
        pte  = rd(atbl);
        ef = 0; el = 0; tbl = 0; ephys = phys_addr;
        if (!pg) begin
            lat = 1; ephys = lin;
        end else if (lvl_bad(pde, wr, usr, wp)) begin
            lat = 3; ef = 1; el = 0;
        end else if (big && pde[7]) begin
            lat = 3; ephys = {pde[31:22], lin[21:0]};
        end else begin
            lat = 5; tbl = 1;
            if (lvl_bad(pte, wr, usr, wp)) begin ef = 1; el = 1; end
            else ephys = {pte[31:12], lin[11:0]};
        end
        if (ef) exp_flin = lin;

        @(negedge clk);
        req_valid = 1; req_lin = lin; req_write = wr; req_user = usr;
        pg_en = pg; wp_en = wp; big_en = big;
        @(negedge clk);
        req_valid = 0;
        for (int k = 1; k <= lat; k++) begin
            if (k > 1) @(negedge clk);
            chk(done == (k == lat), "R11", {tag, " done timing"}, done, (k == lat));
            chk(busy == (k < lat), "R11", {tag, " busy"}, busy, (k < lat));
            if (k == 1)
                chk(mem_rd_en == pg && (!pg || mem_rd_addr == adir), pg ? "R3" : "R2",
                    {tag, " dir read"}, mem_rd_addr, adir);
            if (k == 3 && lat == 5)
                chk(mem_rd_en && mem_rd_addr == atbl, "R4", {tag, " table read"}, mem_rd_addr, atbl);
            if (k == 3 && lat == 3)
                chk(!mem_rd_en, "R5", {tag, " no table read"}, mem_rd_en, 0);
            if (intrude && k == 2) begin
                req_valid = 1; req_lin = 32'hDEAD_0000; pg_en = 0; req_user = 0; req_write = 0;
            end
            if (intrude && k == 3) req_valid = 0;
        end
        chk(fault == ef, "R5", {tag, " fault"}, fault, ef);
        if (ef) chk(fault_lvl == el, "R6", {tag, " fault level"}, fault_lvl, el);
        else    chk(phys_addr == ephys, "R4", {tag, " phys"}, phys_addr, ephys);
        chk(fault_lin == exp_flin, "R10", {tag, " fault_lin"}, fault_lin, exp_flin);
        @(negedge clk);
        chk(!done, "R12", {tag, " single pulse"}, done, 0);
    endtask

    initial begin
        // directory at 0x10000, table at 0x20000
        mem[32'h10018 >> 2] = 32'h0002_0007;   // slot 6: P W U
        mem[32'h1001C >> 2] = 32'h0003_0006;   // slot 7: not present
        mem[32'h10020 >> 2] = 32'h0002_0003;   // slot 8: P W, supervisor only
        mem[32'h10024 >> 2] = 32'h04C0_00A7;   // slot 9: large, P W U A
        mem[32'h20008 >> 2] = 32'h0005_5027;   // tbl 2: P W U A
        mem[32'h2000C >> 2] = 32'h0006_6006;   // tbl 3: not present
        mem[32'h20010 >> 2] = 32'h0007_7003;   // tbl 4: supervisor only
        mem[32'h20014 >> 2] = 32'h0008_8005;   // tbl 5: read-only, user

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!done && !fault && !fault_lvl && !busy && !mem_rd_en, "R1", "reset controls",
            {done, fault, fault_lvl, busy, mem_rd_en}, 0);
        chk(phys_addr == 0 && fault_lin == 0, "R1", "reset regs", phys_addr | fault_lin, 0);

        do_req(32'h1234_5678, 0, 1, 0, 0, 0, 0, "R2 paging off");
        do_req(32'h0180_2038, 0, 0, 1, 0, 0, 0, "R3 R4 walk 6/2/0x38");
        do_req(32'h0180_2FFF, 1, 1, 1, 0, 0, 1, "R4 R11 user write intruded");
        do_req(32'h01C0_0010, 0, 0, 1, 0, 0, 0, "R5 dir absent");
        do_req(32'h0180_2010, 0, 0, 1, 0, 0, 0, "R10 hold after success");
        do_req(32'h0180_3004, 0, 0, 1, 0, 0, 0, "R6 table absent");
        do_req(32'h0200_2000, 0, 1, 1, 0, 0, 0, "R7 user to sup dir");
        do_req(32'h0200_2000, 0, 0, 1, 0, 0, 0, "R7 sup to sup dir");
        do_req(32'h0180_4000, 0, 1, 1, 0, 0, 0, "R7 user to sup table");
        do_req(32'h0180_5100, 1, 1, 1, 0, 0, 0, "R8 user write ro");
        do_req(32'h0180_5100, 1, 0, 1, 0, 0, 0, "R8 sup write ro wp off");
        do_req(32'h0180_5100, 1, 0, 1, 1, 0, 0, "R8 sup write ro wp on");
        do_req(32'h0180_5100, 0, 1, 1, 1, 0, 0, "R8 user read ro");
        do_req(32'h0241_2345, 0, 1, 1, 0, 1, 0, "R9 large page");
        do_req(32'h0241_2345, 0, 1, 1, 0, 0, 0, "R9 large disabled");
        do_req(32'h0241_2345, 0, 0, 0, 0, 1, 0, "R2 paging off again");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        bad++;
        $display("FAIL watchdog act=%0d exp=0", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule